// File: doc/BRIEF.md
# Three-Colour Channel Code Register Bank

This block is the control register file for a red/green/blue analog front end. For each colour channel it holds an 8-bit offset code and an 8-bit gain code. It also holds one setup register that carries a 2-bit output-delay select and a set of reserved bits with fixed values. The per-channel codes and the delay select are driven out as parallel outputs, so the analog side can use them directly.

A host reaches the bank through a simple synchronous port. It supplies a 4-bit address, 8-bit write data and a write strobe. Read data is combinational from the address. Each code set has two kinds of address. A write to a per-channel address changes one colour only. A write to a broadcast address loads the same value into all three colours on the same clock edge, so a balanced setting takes one write instead of three.

The address map is:

| Address | Register |
|---|---|
| 0 | setup |
| 1, 2, 3 | red, green and blue offset |
| 4 | broadcast offset |
| 5, 6, 7 | red, green and blue gain |
| 8 | broadcast gain |
| 9 to 15 | unused |

Top module: `rgbChanRegs`

## Requirements
- R1: After reset, every offset code output reads 0x80. Offset codes are packed into `offsetCodes` with red in bits [7:0], green in [15:8] and blue in [23:16].
- R2: After reset, every gain code output reads 0x00. The packing in `gainCodes` is the same as in `offsetCodes`.
- R3: A write to a per-channel address (offset 1/2/3, gain 5/6/7 for red/green/blue) updates only that channel's register on the clock edge that samples the write. A read of that address returns the channel's current value.
- R4: A write to address 4 loads the written value into all three offset registers on the same edge.
- R5: A write to address 8 loads the written value into all three gain registers on the same edge.
- R6: The delay select `dlySel` (setup register bits [1:0]) resets to 2'b11. Writing code 00, 01 or 10 to address 0 loads that code. The codes select an output delay of 8 ns, 12 ns and 14 ns in that order.
- R7: A write to address 0 whose bits [1:0] are 2'b11, the invalid code, leaves `dlySel` unchanged.
- R8: The reserved setup bits ignore written data. A read of address 0 always returns bit 7 as 1 and bits [6:2] as 0.
- R9: A read of broadcast address 4 returns the red offset. A read of broadcast address 8 returns the red gain.
- R10: Addresses 9 to 15 read 0x00, and writes to them change no output.
- R11: With `wrEn` low, no register changes, whatever the address and data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current address (combinational) |
| offsetCodes | output | 24 | Offset codes: red [7:0], green [15:8], blue [23:16] |
| gainCodes | output | 24 | Gain codes: red [7:0], green [15:8], blue [23:16] |
| dlySel | output | 2 | Output-delay select code |

## Verification
The checker tests the following on every cycle:
- broadcast writes fan out to all three channels;
- an invalid delay code leaves the field untouched;
- the reserved setup bits, the unused addresses and the broadcast read-back read their fixed values;
- nothing changes while the write strobe is low.

Reset defaults, isolation of one channel from its neighbours on a per-channel write, and the acceptance of each valid delay code can only be shown by the bench's scenarios. The bench compares every output against a register model that it keeps from the requirements. It does this after directed writes and after a long run of seeded random writes and reads that mixes broadcast, per-channel, setup and unused addresses.

// File: rtl/rgbRegPkg.sv
package rgbRegPkg;
  localparam int CH_COUNT = 3;
  localparam int CH_W     = $clog2(CH_COUNT);

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_SETUP = 2'd1,
    RD_OFF   = 2'd2,
    RD_GAIN  = 2'd3
  } rdKind_t;

  typedef struct packed {
    logic                setupWr;
    logic [CH_COUNT-1:0] offWr;
    logic [CH_COUNT-1:0] gainWr;
    rdKind_t             rdKind;
    logic [CH_W-1:0]     rdCh;
  } regStrobes_t;
endpackage

// File: rtl/rgbRegCtl.sv
module rgbRegCtl
  import rgbRegPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strobes
);
  localparam int SETUP_ADDR = 0;
  localparam int OFF_BASE   = SETUP_ADDR + 1;
  localparam int OFF_ALL    = OFF_BASE + CH_COUNT;
  localparam int GAIN_BASE  = OFF_ALL + 1;
  localparam int GAIN_ALL   = GAIN_BASE + CH_COUNT;

  always_comb begin
    strobes = '0;
    strobes.rdKind = RD_NONE;
    if (addr == ADDR_W'(SETUP_ADDR)) begin
      strobes.rdKind  = RD_SETUP;
      strobes.setupWr = wrEn;
    end
    if (addr == ADDR_W'(OFF_ALL)) begin
      strobes.rdKind = RD_OFF;
      strobes.offWr  = {CH_COUNT{wrEn}};
    end
    if (addr == ADDR_W'(GAIN_ALL)) begin
      strobes.rdKind = RD_GAIN;
      strobes.gainWr = {CH_COUNT{wrEn}};
    end
    for (int ch = 0; ch < CH_COUNT; ch++) begin
      if (addr == ADDR_W'(OFF_BASE + ch)) begin
        strobes.rdKind    = RD_OFF;
        strobes.rdCh      = CH_W'(ch);
        strobes.offWr[ch] = wrEn;
      end
      if (addr == ADDR_W'(GAIN_BASE + ch)) begin
        strobes.rdKind     = RD_GAIN;
        strobes.rdCh       = CH_W'(ch);
        strobes.gainWr[ch] = wrEn;
      end
    end
  end
endmodule

// File: rtl/rgbRegDp.sv
module rgbRegDp
  import rgbRegPkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          DLY_W     = 2,
  parameter logic [DATA_W-1:0] OFF_RST   = 8'h80,
  parameter logic [DATA_W-1:0] GAIN_RST  = 8'h00,
  parameter logic [DLY_W-1:0]  DLY_RST   = 2'b11,
  parameter logic [DLY_W-1:0]  DLY_BAD   = 2'b11,
  parameter logic [DATA_W-1:0] SETUP_FIX = 8'h80
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobes_t                strobes,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic [CH_COUNT*DATA_W-1:0] offsetCodes,
  output logic [CH_COUNT*DATA_W-1:0] gainCodes,
  output logic [DLY_W-1:0]           dlySel
);
  logic [DATA_W-1:0] offReg  [CH_COUNT];
  logic [DATA_W-1:0] gainReg [CH_COUNT];
  logic [DLY_W-1:0]  dlyReg;
  logic [DATA_W-1:0] setupView;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offReg[ch]  <= OFF_RST;
        gainReg[ch] <= GAIN_RST;
      end else begin
        if (strobes.offWr[ch])  offReg[ch]  <= wrData;
        if (strobes.gainWr[ch]) gainReg[ch] <= wrData;
      end
    end
    assign offsetCodes[ch*DATA_W +: DATA_W] = offReg[ch];
    assign gainCodes[ch*DATA_W +: DATA_W]   = gainReg[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dlyReg <= DLY_RST;
    else if (strobes.setupWr && (wrData[DLY_W-1:0] != DLY_BAD))
      dlyReg <= wrData[DLY_W-1:0];
  end

  assign dlySel    = dlyReg;
  assign setupView = {SETUP_FIX[DATA_W-1:DLY_W], dlyReg};

  always_comb begin
    unique case (strobes.rdKind)
      RD_SETUP: rdData = setupView;
      RD_OFF:   rdData = offReg[strobes.rdCh];
      RD_GAIN:  rdData = gainReg[strobes.rdCh];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/rgbChanRegs.sv
module rgbChanRegs
  import rgbRegPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DLY_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic [CH_COUNT*DATA_W-1:0] offsetCodes,
  output logic [CH_COUNT*DATA_W-1:0] gainCodes,
  output logic [DLY_W-1:0]           dlySel
);
  regStrobes_t strobes;

  rgbRegCtl #(.ADDR_W(ADDR_W)) i_ctl (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes)
  );

  rgbRegDp #(.DATA_W(DATA_W), .DLY_W(DLY_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .rdData      (rdData),
    .offsetCodes (offsetCodes),
    .gainCodes   (gainCodes),
    .dlySel      (dlySel)
  );
endmodule

// File: rtl/rgbChanRegsChk.sv
module rgbChanRegsChk
  import rgbRegPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DLY_W  = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wrData,
  input logic [DATA_W-1:0]          rdData,
  input logic [CH_COUNT*DATA_W-1:0] offsetCodes,
  input logic [CH_COUNT*DATA_W-1:0] gainCodes,
  input logic [DLY_W-1:0]           dlySel
);
  localparam logic [ADDR_W-1:0] A_SETUP    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OFF_ALL  = ADDR_W'(1 + CH_COUNT);
  localparam logic [ADDR_W-1:0] A_GAIN_ALL = ADDR_W'(2 + 2 * CH_COUNT);

  AST_BCAST_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OFF_ALL) |=> (offsetCodes == {CH_COUNT{$past(wrData)}})); // R4

  AST_BCAST_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_GAIN_ALL) |=> (gainCodes == {CH_COUNT{$past(wrData)}})); // R5

  AST_BAD_DLY_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SETUP && wrData[DLY_W-1:0] == 2'b11) |=> $stable(dlySel)); // R7

  AST_SETUP_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_SETUP) |-> (rdData[DATA_W-1:DLY_W] == 6'b100000)); // R8

  AST_BCAST_READ: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_OFF_ALL) |-> (rdData == offsetCodes[DATA_W-1:0])); // R9

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr > A_GAIN_ALL) |-> (rdData == '0)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(offsetCodes) && $stable(gainCodes) && $stable(dlySel))); // R11
endmodule

bind rgbChanRegs rgbChanRegsChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
  .offsetCodes(offsetCodes), .gainCodes(gainCodes), .dlySel(dlySel)
);

// File: tb/test_rgbChanRegs.sv
`timescale 1ns/1ps
module test_rgbChanRegs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [23:0] offsetCodes;
  logic [23:0] gainCodes;
  logic [1:0]  dlySel;

  int nTests = 0;
  int nFails = 0;
  logic [7:0] mOff [3];
  logic [7:0] mGain [3];
  logic [1:0] mDly;

  rgbChanRegs i_rgbChanRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .offsetCodes(offsetCodes), .gainCodes(gainCodes), .dlySel(dlySel)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] expRead(input logic [3:0] a);
    case (a)
      4'd0:             return {6'b100000, mDly};
      4'd1, 4'd2, 4'd3: return mOff[a - 1];
      4'd4:             return mOff[0];
      4'd5, 4'd6, 4'd7: return mGain[a - 5];
      4'd8:             return mGain[0];
      default:          return 8'h00;
    endcase
  endfunction

  function automatic void modelWrite(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'd0:             if (d[1:0] != 2'b11) mDly = d[1:0];
      4'd1, 4'd2, 4'd3: mOff[a - 1] = d;
      4'd4:             for (int c = 0; c < 3; c++) mOff[c] = d;
      4'd5, 4'd6, 4'd7: mGain[a - 5] = d;
      4'd8:             for (int c = 0; c < 3; c++) mGain[c] = d;
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    check(req, offsetCodes, {mOff[2], mOff[1], mOff[0]});
    check(req, gainCodes, {mGain[2], mGain[1], mGain[0]});
    check(req, dlySel, mDly);
  endtask

  task automatic readCheck(input string req, input logic [3:0] a);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdData, expRead(a));
  endtask

  // drive at negedge, register updates at the next posedge, sample at the following negedge
  task automatic cycle(input logic we, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = we; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (we) modelWrite(a, d);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int c = 0; c < 3; c++) begin mOff[c] = 8'h80; mGain[c] = 8'h00; end
    mDly = 2'b11;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 R2 R6 reset state
    #1;
    check("R1", offsetCodes, 24'h808080);
    check("R2", gainCodes, 24'h000000);
    check("R6", dlySel, 2'b11);
    readCheck("R8", 4'd0);

    // R3 per-channel isolation
    cycle(1'b1, 4'd2, 8'h5A); checkOutputs("R3");
    cycle(1'b1, 4'd7, 8'hC3); checkOutputs("R3");
    readCheck("R3", 4'd2);
    readCheck("R3", 4'd7);

    // R4 R5 broadcast
    cycle(1'b1, 4'd4, 8'h11); checkOutputs("R4");
    check("R4", offsetCodes, 24'h111111);
    cycle(1'b1, 4'd8, 8'hFE); checkOutputs("R5");
    check("R5", gainCodes, 24'hFEFEFE);

    // R9 broadcast read after red diverges
    cycle(1'b1, 4'd1, 8'h77);
    cycle(1'b1, 4'd5, 8'h99);
    readCheck("R9", 4'd4);
    readCheck("R9", 4'd8);

    // R6 R7 R8 setup
    cycle(1'b1, 4'd0, 8'h01); check("R6", dlySel, 2'b01);
    cycle(1'b1, 4'd0, 8'hFF); check("R7", dlySel, 2'b01);
    readCheck("R8", 4'd0);
    cycle(1'b1, 4'd0, 8'h7E); check("R6", dlySel, 2'b10);
    readCheck("R8", 4'd0);
    cycle(1'b1, 4'd0, 8'h00); check("R6", dlySel, 2'b00);

    // R10 unused addresses
    for (int a = 9; a < 16; a++) begin
      cycle(1'b1, 4'(a), 8'hA5); checkOutputs("R10");
      readCheck("R10", 4'(a));
    end

    // R11 no write strobe
    cycle(1'b0, 4'd4, 8'h3C); checkOutputs("R11");
    cycle(1'b0, 4'd0, 8'h02); checkOutputs("R11");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ra;
      logic [7:0] rd;
      logic       rw;
      ra = 4'($urandom_range(0, 15));
      rd = 8'($urandom);
      rw = ($urandom_range(0, 3) != 0);
      cycle(rw, ra, rd);
      checkOutputs(rw ? "R3" : "R11");
      readCheck("R9", 4'($urandom_range(0, 15)));
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule